// File: doc/BRIEF.md
# LPC Power-Down Entry Sequencer

This block orders the three signals that take a Low Pin Count bus into and out of a low-power or reset condition: a power-down (suspend status) indication, the bus reset, and the parking of the frame strobe and the four address/data lines. An orderly low-power request raises power-down first. One cycle later the bus is parked. The bus reset follows only after a minimum settling time, which is set in microseconds and converted to clock cycles from the clock frequency.

A global reset request takes a different path. It raises power-down and bus reset on the same edge with no settling time, and it cuts short any orderly entry that is still waiting. On wake, the bus reset drops first. Power-down and bus parking are released one cycle later.

While the bus is not parked, the host engine's frame strobe and AD drive pass through unchanged. A parameter chooses how parked AD lines behave: they are either released (output enable low) or actively driven to zero.

Top module: `lpc_pd_sequencer`

## Requirements
- R1: After reset, susp_o and lrst_o are 0 and frame_n_o, ad_o and ad_oe_o equal frame_n_i, ad_i and ad_oe_i.
- R2: When lp_req_i is seen high in the idle state, susp_o is 1 from the next edge, with lrst_o still 0 and the bus not yet parked.
- R3: From one cycle after susp_o rises on the orderly path, frame_n_o is 0 and the AD lines are parked. Parking only happens while susp_o is 1.
- R4: On the orderly path lrst_o rises exactly DELAY_US*CLK_MHZ cycles after susp_o rose, and never earlier.
- R5: When grst_req_i is seen high in any state, susp_o and lrst_o are both 1 from the next edge. From idle, both rise on the same edge.
- R6: A grst_req_i during the orderly settling wait abandons the wait, and lrst_o rises on the next edge.
- R7: When parked with PARK_TRISTATE=1, ad_oe_o is 0. When parked with PARK_TRISTATE=0, ad_oe_o is 1 and ad_o is 4'h0.
- R8: When wake_i is seen high in the reset state while grst_req_i is low, lrst_o falls on the next edge while susp_o and parking hold. One cycle later susp_o falls and parking is released.
- R9: wake_i has no effect during the orderly settling wait, and has no effect while grst_req_i is high.
- R10: When the bus is not parked, frame_n_o, ad_o and ad_oe_o follow the host inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_req_i | input | 1 | Orderly low-power entry request (level) |
| grst_req_i | input | 1 | Global reset request (level) |
| wake_i | input | 1 | Exit request from the reset state |
| frame_n_i | input | 1 | Frame strobe from the host engine, active low |
| ad_i | input | 4 | AD output value from the host engine |
| ad_oe_i | input | 1 | AD output enable from the host engine |
| susp_o | output | 1 | Power-down / suspend status, active high |
| lrst_o | output | 1 | Bus reset, active high |
| frame_n_o | output | 1 | Frame strobe to the pad, forced low when parked |
| ad_o | output | 4 | AD value to the pad |
| ad_oe_o | output | 1 | AD output enable to the pad |

## Verification
The orderly settling countdown and the global reset path can collide. A global reset can arrive in the same cycle that the wait is still counting, and a wake can arrive while the global request is still held. The bench raises grst_req_i ten cycles into an orderly wait and expects lrst_o on the very next edge, well before the settling count would expire. It also pulses wake_i both while the wait is counting and while the global request is high, and expects the outputs to stay unchanged in both cases. A second instance with the opposite parking option shares all the stimulus, so that both AD variants are judged on the same cycles.

// File: rtl/lpc_pd_pkg.sv
package lpc_pd_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE    = 3'd0,
      ST_PD_ASSERT = 3'd1,
      ST_PD_WAIT   = 3'd2,
      ST_IN_RESET  = 3'd3,
      ST_EXIT      = 3'd4
   } pd_state_e;

   localparam int AD_W = 4;

endpackage

// File: rtl/lpc_pd_timer.sv
module lpc_pd_timer #(
   parameter int DELAY_CYCLES = 7500
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic done_o
);
   localparam int CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q <= '0;
      else if (!run_i)      cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign done_o = run_i && (cnt_q == LAST);

   a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && $past(run_i) && $past(cnt_q) != LAST |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/lpc_pd_fsm.sv
module lpc_pd_fsm
   import lpc_pd_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      lp_req_i,
   input  logic      grst_req_i,
   input  logic      wake_i,
   input  logic      wait_done_i,
   output pd_state_e state_o
);
   pd_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (grst_req_i) begin
         state_d = ST_IN_RESET;
      end else begin
         unique case (state_q)
            ST_ACTIVE:    if (lp_req_i) state_d = ST_PD_ASSERT;
            ST_PD_ASSERT: state_d = ST_PD_WAIT;
            ST_PD_WAIT:   if (wait_done_i) state_d = ST_IN_RESET;
            ST_IN_RESET:  if (wake_i) state_d = ST_EXIT;
            ST_EXIT:      state_d = ST_ACTIVE;
            default:      state_d = ST_ACTIVE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_ACTIVE;
      else         state_q <= state_d;
   end

   assign state_o = state_q;

   a_r9_no_wake_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(state_q) == ST_PD_WAIT && !$past(grst_req_i) && !$past(wait_done_i)
      |-> state_q == ST_PD_WAIT);
   a_r8_exit_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(state_q) == ST_EXIT && !$past(grst_req_i) |-> state_q == ST_ACTIVE);
endmodule

// File: rtl/lpc_pd_park.sv
module lpc_pd_park
   import lpc_pd_pkg::*;
#(
   parameter bit PARK_TRISTATE = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            park_i,
   input  logic            frame_n_i,
   input  logic [AD_W-1:0] ad_i,
   input  logic            ad_oe_i,
   output logic            frame_n_o,
   output logic [AD_W-1:0] ad_o,
   output logic            ad_oe_o
);
   assign frame_n_o = park_i ? 1'b0 : frame_n_i;
   assign ad_o      = park_i ? '0   : ad_i;

   generate
      if (PARK_TRISTATE) begin : g_park_release
         assign ad_oe_o = park_i ? 1'b0 : ad_oe_i;
         a_r7_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
            park_i |-> !ad_oe_o);
      end else begin : g_park_drive_low
         assign ad_oe_o = park_i ? 1'b1 : ad_oe_i;
         a_r7_driven_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            park_i |-> ad_oe_o && ad_o == '0);
      end
   endgenerate

   a_r3_frame_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      park_i |-> !frame_n_o);
   a_r10_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !park_i |-> frame_n_o == frame_n_i && ad_oe_o == ad_oe_i);
endmodule

// File: rtl/lpc_pd_sequencer.sv
module lpc_pd_sequencer
   import lpc_pd_pkg::*;
#(
   parameter int CLK_MHZ       = 250,
   parameter int DELAY_US      = 30,
   parameter bit PARK_TRISTATE = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            lp_req_i,
   input  logic            grst_req_i,
   input  logic            wake_i,
   input  logic            frame_n_i,
   input  logic [AD_W-1:0] ad_i,
   input  logic            ad_oe_i,
   output logic            susp_o,
   output logic            lrst_o,
   output logic            frame_n_o,
   output logic [AD_W-1:0] ad_o,
   output logic            ad_oe_o
);
   localparam int DELAY_CYCLES = CLK_MHZ * DELAY_US;
   localparam int AGE_W = $clog2(DELAY_CYCLES + 1);

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be positive");
      end
      if (DELAY_CYCLES < 2) begin : g_bad_delay
         $error("settling time must span at least two cycles");
      end
   endgenerate

   pd_state_e state;
   logic      wait_done;
   logic      timer_run;
   logic      park;

   assign timer_run = (state == ST_PD_ASSERT) || (state == ST_PD_WAIT);

   lpc_pd_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (timer_run),
      .done_o (wait_done)
   );

   lpc_pd_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lp_req_i    (lp_req_i),
      .grst_req_i  (grst_req_i),
      .wake_i      (wake_i),
      .wait_done_i (wait_done),
      .state_o     (state)
   );

   assign susp_o = (state != ST_ACTIVE);
   assign lrst_o = (state == ST_IN_RESET);
   assign park   = (state == ST_PD_WAIT) || (state == ST_IN_RESET) || (state == ST_EXIT);

   lpc_pd_park #(.PARK_TRISTATE(PARK_TRISTATE)) u_park (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .park_i    (park),
      .frame_n_i (frame_n_i),
      .ad_i      (ad_i),
      .ad_oe_i   (ad_oe_i),
      .frame_n_o (frame_n_o),
      .ad_o      (ad_o),
      .ad_oe_o   (ad_oe_o)
   );

   // checker: cycles elapsed since power-down rose, saturating
   logic [AGE_W-1:0] susp_age_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              susp_age_q <= '0;
      else if (!susp_o)                         susp_age_q <= '0;
      else if (susp_age_q != AGE_W'(DELAY_CYCLES)) susp_age_q <= susp_age_q + 1'b1;
   end

   a_r4_settle_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lrst_o) && !$past(grst_req_i) |-> susp_age_q == AGE_W'(DELAY_CYCLES));
   a_r5_grst_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(grst_req_i) |-> lrst_o && susp_o);
   a_r3_park_needs_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_n_o && frame_n_i |-> susp_o);
   a_r8_reset_drops_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(susp_o) |-> !lrst_o && !$past(lrst_o));
   a_r2_susp_before_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(susp_o) && !$past(grst_req_i) |-> !lrst_o && frame_n_o == frame_n_i);
endmodule

// File: tb/lpc_pd_sequencer_tb.sv
module lpc_pd_sequencer_tb;
   localparam int CLK_MHZ  = 250;
   localparam int DELAY_US = 1;
   localparam int D        = CLK_MHZ * DELAY_US;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_req = 1'b0, grst_req = 1'b0, wake = 1'b0;
   logic       frame_n_in = 1'b1;
   logic [3:0] ad_in = 4'hA;
   logic       ad_oe_in = 1'b1;

   logic       susp_a, lrst_a, frame_a, oe_a;
   logic [3:0] ad_a;
   logic       susp_b, lrst_b, frame_b, oe_b;
   logic [3:0] ad_b;

   always #2 clk = ~clk;

   lpc_pd_sequencer #(.CLK_MHZ(CLK_MHZ), .DELAY_US(DELAY_US), .PARK_TRISTATE(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_req), .grst_req_i(grst_req), .wake_i(wake),
      .frame_n_i(frame_n_in), .ad_i(ad_in), .ad_oe_i(ad_oe_in),
      .susp_o(susp_a), .lrst_o(lrst_a), .frame_n_o(frame_a), .ad_o(ad_a), .ad_oe_o(oe_a));

   lpc_pd_sequencer #(.CLK_MHZ(CLK_MHZ), .DELAY_US(DELAY_US), .PARK_TRISTATE(1'b0)) u_dut_lo (
      .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_req), .grst_req_i(grst_req), .wake_i(wake),
      .frame_n_i(frame_n_in), .ad_i(ad_in), .ad_oe_i(ad_oe_in),
      .susp_o(susp_b), .lrst_o(lrst_b), .frame_n_o(frame_b), .ad_o(ad_b), .ad_oe_o(oe_b));

   typedef struct {
      string  tag;
      longint cyc;
      logic   susp;
      logic   lrst;
      logic   park;
   } exp_t;

   exp_t   sb_q[$];
   longint cyc = 0;
   int     n_chk = 0;
   int     n_fail = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic void expect_at(string tag, longint c, logic s, logic r, logic p);
      exp_t e;
      e.tag = tag; e.cyc = c; e.susp = s; e.lrst = r; e.park = p;
      sb_q.push_back(e);
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
      end
   endtask

   // monitor: pops items when their cycle comes up
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
         exp_t e;
         e = sb_q.pop_front();
         if (e.cyc < cyc) begin
            n_chk++; n_fail++;
            $display("FAIL %s missed slot: actual cycle %0d expected %0d", e.tag, cyc, e.cyc);
         end else begin
            chk(e.tag, "susp", {7'd0, susp_a}, {7'd0, e.susp});
            chk(e.tag, "lrst", {7'd0, lrst_a}, {7'd0, e.lrst});
            chk(e.tag, "susp_lo", {7'd0, susp_b}, {7'd0, e.susp});
            chk(e.tag, "lrst_lo", {7'd0, lrst_b}, {7'd0, e.lrst});
            if (e.park) begin
               chk(e.tag, "frame", {7'd0, frame_a}, 8'd0);
               chk({e.tag, "/R7"}, "oe_tri", {7'd0, oe_a}, 8'd0);
               chk({e.tag, "/R7"}, "oe_lo", {7'd0, oe_b}, 8'd1);
               chk({e.tag, "/R7"}, "ad_lo", {4'd0, ad_b}, 8'd0);
            end else begin
               chk({e.tag, "/R10"}, "frame", {7'd0, frame_a}, {7'd0, frame_n_in});
               chk({e.tag, "/R10"}, "ad", {4'd0, ad_a}, {4'd0, ad_in});
               chk({e.tag, "/R10"}, "oe", {7'd0, oe_a}, {7'd0, ad_oe_in});
               chk({e.tag, "/R10"}, "oe_lo", {7'd0, oe_b}, {7'd0, ad_oe_in});
            end
         end
      end
   end

   task automatic step(int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic drain();
      while (sb_q.size() > 0) step(1);
   endtask

   // exit path from the reset state: R8
   task automatic do_exit(string tag);
      longint n;
      n = cyc;
      wake = 1'b1;
      expect_at({tag, "/R8 reset drops first"}, n + 1, 1'b1, 1'b0, 1'b1);
      expect_at({tag, "/R8 released"}, n + 2, 1'b0, 1'b0, 1'b0);
      step(1);
      wake = 1'b0;
      drain();
      step(2);
   endtask

   initial begin : main
      longint n;
      step(3);
      rst_n = 1'b1;
      expect_at("R1 reset state", cyc + 1, 1'b0, 1'b0, 1'b0);
      drain();

      // orderly entry with a wake during the wait
      n = cyc;
      lp_req = 1'b1;
      expect_at("R2 susp first", n + 1, 1'b1, 1'b0, 1'b0);
      expect_at("R3 parked", n + 2, 1'b1, 1'b0, 1'b1);
      expect_at("R9 wake in wait ignored", n + 7, 1'b1, 1'b0, 1'b1);
      expect_at("R4 not early", n + D, 1'b1, 1'b0, 1'b1);
      expect_at("R4 reset on time", n + D + 1, 1'b1, 1'b1, 1'b1);
      step(2);
      lp_req = 1'b0;
      ad_in = 4'h5;
      step(3);
      wake = 1'b1;
      step(1);
      wake = 1'b0;
      drain();
      step(1);
      do_exit("orderly");

      // global reset from idle, wake while still held
      ad_in = 4'hC;
      ad_oe_in = 1'b0;
      n = cyc;
      grst_req = 1'b1;
      expect_at("R5 together", n + 1, 1'b1, 1'b1, 1'b1);
      expect_at("R9 wake under grst ignored", n + 4, 1'b1, 1'b1, 1'b1);
      step(3);
      wake = 1'b1;
      step(1);
      wake = 1'b0;
      grst_req = 1'b0;
      drain();
      step(1);
      do_exit("global");

      // orderly entry aborted by global reset
      ad_oe_in = 1'b1;
      n = cyc;
      lp_req = 1'b1;
      expect_at("R2 susp first", n + 1, 1'b1, 1'b0, 1'b0);
      expect_at("R6 still waiting", n + 10, 1'b1, 1'b0, 1'b1);
      expect_at("R6 abort immediate", n + 11, 1'b1, 1'b1, 1'b1);
      step(1);
      lp_req = 1'b0;
      step(9);
      grst_req = 1'b1;
      step(1);
      grst_req = 1'b0;
      drain();
      step(1);
      do_exit("abort");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule